// File: doc/BRIEF.md
# Integer ALU Stage with Dual-Width Carry and Overflow Flags

This block is a purely combinational execute stage for 64-bit integer work. It takes two operands, a two-bit carry-in field, a summary-overflow bit and a small operation record made of a kind code and a length. From these it produces a 64-bit result, carry and overflow flags at both 64-bit and 32-bit widths, and a four-bit condition field. The operation record is passed through so that later stages see exactly what this stage was given.

Four operations are supported:

- An add with carry.
- A sign extension from a byte, halfword or word.
- A compare-style add that ignores the carry-in.
- A byte search that reports whether the low byte of one operand appears anywhere in the other.

Both carry widths and both overflow widths come out of a single adder pass. Any code the stage does not recognise gives an all-zero output.

Top module: `alu_stage`

## Requirements
- R1: With op_kind_i = 1 (add), the 65-bit value {ca_o[0], result_o} equals a_i + b_i + ca_i[0].
- R2: With op_kind_i = 1, ca_o[1] equals bit 32 of a_i[31:0] + b_i[31:0] + ca_i[0]. Input bit ca_i[1] has no effect on any output for any operation.
- R3: With op_kind_i = 1, ov_o[0] is 1 exactly when a_i[63] equals b_i[63] and result_o[63] differs from a_i[63].
- R4: With op_kind_i = 1, ov_o[1] is 1 exactly when a_i[31] equals b_i[31] and result_o[31] differs from a_i[31].
- R5: With op_kind_i = 2 (sign extension), an op_len_i of 1, 2 or 4 keeps the low 8, 16 or 32 bits of a_i and fills every higher bit with the top bit of the kept field. Any other op_len_i copies a_i unchanged.
- R6: With op_kind_i = 3 (compare add), result_o equals the low 64 bits of a_i + b_i, whatever the carry-in. Both ca_o bits and both ov_o bits are 0.
- R7: With op_kind_i = 4 (byte search), cr_o[2] is 1 exactly when a_i[7:0] equals at least one of the eight bytes of b_i. result_o is 0.
- R8: cr_o[0] copies so_i for kinds 1 and 3 and is 0 otherwise. cr_o[1] and cr_o[3] are always 0, and cr_o[2] is 0 outside kind 4. For kinds 2 and 4, ca_o and ov_o are 0.
- R9: op_kind_o and op_len_o equal op_kind_i and op_len_i in the same cycle, for every input code.
- R10: For op_kind_i of 0, 5, 6 or 7, result_o, ca_o, ov_o and cr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| ca_i | input | 2 | Carry-in; bit 0 is the 64-bit carry, bit 1 the 32-bit carry |
| so_i | input | 1 | Summary overflow, copied into the condition field |
| op_kind_i | input | 3 | Operation code: 1 add, 2 sign extend, 3 compare add, 4 byte search |
| op_len_i | input | 4 | Data length in bytes, used by sign extension |
| result_o | output | 64 | Result value |
| ca_o | output | 2 | Carry-out; bit 0 is 64-bit, bit 1 is 32-bit |
| ov_o | output | 2 | Overflow; bit 0 is 64-bit, bit 1 is 32-bit |
| cr_o | output | 4 | Condition field; bit 2 is byte match, bit 0 is the summary copy |
| op_kind_o | output | 3 | Passed-through operation code |
| op_len_o | output | 4 | Passed-through data length |

## Verification
Immediate assertions check the following on every input change:

- The 65-bit add identity.
- That either overflow flag is set only under the same-sign, flipped-result condition.
- That a reported byte match has a real matching byte behind it.
- The sign fill for one-byte extension.
- That an unrecognised code leaves every output at zero.

Some behaviours can only be shown by the bench's scenarios:

- That an overflow flag does fire whenever the condition holds.
- That the compare ignores a carry-in of 1.
- That the 32-bit carry input has no effect.
- That unsupported lengths copy the operand.

The bench drives directed corners for these and random mixes of all eight codes.

// File: rtl/alu_stg_pkg.sv
package alu_stg_pkg;
  localparam int XLEN   = 64;
  localparam int HLEN   = 32;
  localparam int KIND_W = 3;
  localparam int LEN_W  = 4;
  localparam int CR_W   = 4;
  localparam int CR_MATCH = 2;
  localparam int CR_SUMOV = 0;

  typedef enum logic [KIND_W-1:0] {
    K_NONE     = 3'd0,
    K_ADD      = 3'd1,
    K_SIGNX    = 3'd2,
    K_CMPADD   = 3'd3,
    K_BYTEFIND = 3'd4
  } kind_e;

  // full-width add with carry, carry-out in the top bit
  function automatic logic [XLEN:0] wide_add(input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b,
                                             input logic cin);
    return {1'b0, a} + {1'b0, b} + {{XLEN{1'b0}}, cin};
  endfunction

  // carry out of the low half sum
  function automatic logic half_carry(input logic [XLEN-1:0] a,
                                      input logic [XLEN-1:0] b,
                                      input logic cin);
    logic [HLEN:0] s;
    s = {1'b0, a[HLEN-1:0]} + {1'b0, b[HLEN-1:0]} + {{HLEN{1'b0}}, cin};
    return s[HLEN];
  endfunction

  // signed overflow: operands agree in sign, result does not
  function automatic logic sign_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder
  import alu_stg_pkg::*;
#(
  parameter int W = XLEN,
  parameter int H = HLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         co_full,
  output logic         co_half,
  output logic         ov_full,
  output logic         ov_half
);
  logic [W:0] total;

  assign total   = wide_add(a, b, cin);
  assign sum     = total[W-1:0];
  assign co_full = total[W];
  assign co_half = half_carry(a, b, cin);
  assign ov_full = sign_ovf(a[W-1], b[W-1], total[W-1]);
  assign ov_half = sign_ovf(a[H-1], b[H-1], total[H-1]);
endmodule

// File: rtl/alu_signx.sv
module alu_signx
  import alu_stg_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int LW    = LEN_W,
  parameter int NSIZE = 3
) (
  input  logic [W-1:0]  a,
  input  logic [LW-1:0] len,
  output logic [W-1:0]  res
);
  logic [W-1:0] ext [NSIZE];

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int KB = 8 << g;
    assign ext[g] = {{(W-KB){a[KB-1]}}, a[KB-1:0]};
  end

  always_comb begin
    res = a;
    for (int g = 0; g < NSIZE; g++) begin
      if (len == LW'(1 << g)) res = ext[g];
    end
  end
endmodule

// File: rtl/alu_bytefind.sv
module alu_bytefind
  import alu_stg_pkg::*;
#(
  parameter int W = XLEN,
  localparam int NB = W / 8
) (
  input  logic [7:0]   key,
  input  logic [W-1:0] hay,
  output logic [NB-1:0] hits,
  output logic         found
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign hits[i] = (hay[i*8 +: 8] == key);
  end
  assign found = |hits;
endmodule

// File: rtl/alu_stage.sv
module alu_stage
  import alu_stg_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int H  = HLEN,
  parameter int KW = KIND_W,
  parameter int LW = LEN_W,
  parameter int CW = CR_W
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [1:0]    ca_i,
  input  logic          so_i,
  input  logic [KW-1:0] op_kind_i,
  input  logic [LW-1:0] op_len_i,
  output logic [W-1:0]  result_o,
  output logic [1:0]    ca_o,
  output logic [1:0]    ov_o,
  output logic [CW-1:0] cr_o,
  output logic [KW-1:0] op_kind_o,
  output logic [LW-1:0] op_len_o
);
  localparam int NB = W / 8;

  kind_e        kind;
  logic         is_add;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_co_full, add_co_half, add_ov_full, add_ov_half;
  logic [W-1:0] sx_res;
  logic [NB-1:0] byte_hits;
  logic         byte_found;
  wire          ca32_in_unused = ca_i[1];

  assign kind    = kind_e'(op_kind_i);
  assign is_add  = (kind == K_ADD);
  assign add_cin = is_add & ca_i[0];

  alu_adder #(.W(W), .H(H)) u_adder (
    .a(a_i), .b(b_i), .cin(add_cin), .sum(add_sum),
    .co_full(add_co_full), .co_half(add_co_half),
    .ov_full(add_ov_full), .ov_half(add_ov_half)
  );

  alu_signx #(.W(W), .LW(LW)) u_signx (
    .a(a_i), .len(op_len_i), .res(sx_res)
  );

  alu_bytefind #(.W(W)) u_bytefind (
    .key(a_i[7:0]), .hay(b_i), .hits(byte_hits), .found(byte_found)
  );

  always_comb begin
    result_o = '0;
    ca_o     = '0;
    ov_o     = '0;
    cr_o     = '0;
    unique case (kind)
      K_ADD: begin
        result_o         = add_sum;
        ca_o             = {add_co_half, add_co_full};
        ov_o             = {add_ov_half, add_ov_full};
        cr_o[CR_SUMOV]   = so_i;
      end
      K_SIGNX:  result_o = sx_res;
      K_CMPADD: begin
        result_o         = add_sum;
        cr_o[CR_SUMOV]   = so_i;
      end
      K_BYTEFIND: cr_o[CR_MATCH] = byte_found;
      default: ;
    endcase
  end

  assign op_kind_o = op_kind_i;
  assign op_len_o  = op_len_i;

  // checks over the port values, next to the output mux
  always_comb begin
    logic real_hit;
    real_hit = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (b_i[i*8 +: 8] == a_i[7:0]) real_hit = 1'b1;
    end
    if (op_kind_i == 3'd1) begin
      assert_add_sum_R1: assert ({ca_o[0], result_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ca_i[0]}));
      assert_ov_full_R3: assert (!ov_o[0] ||
        (a_i[W-1] == b_i[W-1] && result_o[W-1] != a_i[W-1]));
      assert_ov_half_R4: assert (!ov_o[1] ||
        (a_i[H-1] == b_i[H-1] && result_o[H-1] != a_i[H-1]));
    end
    if (op_kind_i == 3'd2 && op_len_i == 4'd1) begin
      assert_signx_byte_R5: assert (result_o[W-1:8] == {(W-8){a_i[7]}}
                                    && result_o[7:0] == a_i[7:0]);
    end
    if (op_kind_i == 3'd4) begin
      assert_match_real_R7: assert (cr_o[2] == real_hit);
    end
    if (op_kind_i == 3'd0 || op_kind_i > 3'd4) begin
      assert_idle_zero_R10: assert (result_o == '0 && ca_o == '0 &&
                                    ov_o == '0 && cr_o == '0);
    end
  end
endmodule

// File: tb/alu_stage_bench.sv
module alu_stage_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a, b;
  logic [1:0]  ca;
  logic        so;
  logic [2:0]  kind;
  logic [3:0]  len;
  logic [63:0] res;
  logic [1:0]  ca_out, ov_out;
  logic [3:0]  cr;
  logic [2:0]  kind_out;
  logic [3:0]  len_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_stage u_alu_stage (
    .a_i(a), .b_i(b), .ca_i(ca), .so_i(so), .op_kind_i(kind), .op_len_i(len),
    .result_o(res), .ca_o(ca_out), .ov_o(ov_out), .cr_o(cr),
    .op_kind_o(kind_out), .op_len_o(len_out)
  );

  // reference model, built from halves and signed views
  typedef struct packed {
    logic [63:0] r;
    logic [1:0]  c;
    logic [1:0]  v;
    logic [3:0]  f;
  } exp_t;

  function automatic exp_t model(input logic [2:0] k, input logic [3:0] l,
                                 input logic [63:0] x, input logic [63:0] y,
                                 input logic [1:0] cin, input logic s);
    exp_t e;
    logic [32:0] lo, hi;
    e = '0;
    case (k)
      3'd1, 3'd3: begin
        lo = {1'b0, x[31:0]} + {1'b0, y[31:0]} + ((k == 3'd1) ? 33'(cin[0]) : 33'd0);
        hi = {1'b0, x[63:32]} + {1'b0, y[63:32]} + 33'(lo[32]);
        e.r = {hi[31:0], lo[31:0]};
        e.f[0] = s;
        if (k == 3'd1) begin
          e.c = {lo[32], hi[32]};
          e.v[0] = ($signed(x) >= 0 && $signed(y) >= 0 && $signed(e.r) < 0) ||
                   ($signed(x) < 0 && $signed(y) < 0 && $signed(e.r) >= 0);
          e.v[1] = ($signed(x[31:0]) >= 0 && $signed(y[31:0]) >= 0 && $signed(e.r[31:0]) < 0) ||
                   ($signed(x[31:0]) < 0 && $signed(y[31:0]) < 0 && $signed(e.r[31:0]) >= 0);
        end
      end
      3'd2: begin
        if (l == 4'd1)      e.r = $signed(x << 56) >>> 56;
        else if (l == 4'd2) e.r = $signed(x << 48) >>> 48;
        else if (l == 4'd4) e.r = $signed(x << 32) >>> 32;
        else                e.r = x;
      end
      3'd4: begin
        for (int i = 0; i < 8; i++) if (8'(y >> (8*i)) == x[7:0]) e.f[2] = 1'b1;
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s kind=%0d len=%0d actual=%h expected=%h", tag, kind, len, act, exp);
    end
  endtask

  function automatic string rtag(input logic [2:0] k);
    case (k)
      3'd1: return "R1";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic run(input logic [2:0] k, input logic [3:0] l, input logic [63:0] x,
                     input logic [63:0] y, input logic [1:0] cin, input logic s);
    exp_t e;
    @(posedge clk);
    kind = k; len = l; a = x; b = y; ca = cin; so = s;
    e = model(k, l, x, y, cin, s);
    @(negedge clk);
    check({rtag(k), " result"}, res, e.r);
    check((k == 3'd1) ? "R1/R2 carry" : "R6/R8/R10 carry", 64'(ca_out), 64'(e.c));
    check((k == 3'd1) ? "R3/R4 overflow" : "R6/R8/R10 overflow", 64'(ov_out), 64'(e.v));
    check((k == 3'd4) ? "R7 cond" : "R8 cond", 64'(cr), 64'(e.f));
    check("R9 kind pass", 64'(kind_out), 64'(k));
    check("R9 len pass", 64'(len_out), 64'(l));
  endtask

  // ca_i[1] must not move any output: compare two runs
  task automatic run_ca32_pair(input logic [2:0] k, input logic [63:0] x, input logic [63:0] y);
    logic [63:0] r0; logic [1:0] c0, v0; logic [3:0] f0;
    @(posedge clk);
    kind = k; len = 4'd4; a = x; b = y; ca = 2'b00; so = 1'b0;
    @(negedge clk);
    r0 = res; c0 = ca_out; v0 = ov_out; f0 = cr;
    @(posedge clk);
    ca = 2'b10;
    @(negedge clk);
    check("R2 ca_i[1] result", res, r0);
    check("R2 ca_i[1] flags", 64'({ca_out, ov_out, cr}), 64'({c0, v0, f0}));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    a = '0; b = '0; ca = '0; so = 1'b0; kind = '0; len = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset-state result", res, 64'd0);
    check("R10 reset-state flags", 64'({ca_out, ov_out, cr}), 64'd0);

    // add corners
    run(3'd1, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'b01, 1'b1);
    run(3'd1, 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 2'b00, 1'b0);
    run(3'd1, 4'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'b00, 1'b0);
    run(3'd1, 4'd0, 64'h0000_0000_7FFF_FFFF, 64'd0, 2'b01, 1'b0);
    run(3'd1, 4'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b00, 1'b1);
    run(3'd1, 4'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 2'b11, 1'b0);
    // sign extension, every length plus unsupported ones
    run(3'd2, 4'd1, 64'h1234_5678_9ABC_DE80, 64'd0, 2'b11, 1'b1);
    run(3'd2, 4'd1, 64'hFFFF_FFFF_FFFF_FF7F, 64'd0, 2'b00, 1'b0);
    run(3'd2, 4'd2, 64'h0000_0000_0000_8001, 64'd0, 2'b00, 1'b0);
    run(3'd2, 4'd4, 64'h0000_0000_8000_0000, 64'd0, 2'b00, 1'b0);
    run(3'd2, 4'd4, 64'hFFFF_FFFF_7FFF_FFFF, 64'd0, 2'b00, 1'b0);
    run(3'd2, 4'd8, 64'hDEAD_BEEF_0BAD_F00D, 64'd0, 2'b00, 1'b0);
    run(3'd2, 4'd3, 64'hDEAD_BEEF_0BAD_F08D, 64'd0, 2'b00, 1'b0);
    // compare with carry-in present
    run(3'd3, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'b11, 1'b1);
    run(3'd3, 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 2'b01, 1'b0);
    // byte search: hit at the top byte, bottom byte, and a miss
    run(3'd4, 4'd0, 64'h0000_0000_0000_00A5, 64'hA500_0000_0000_0000, 2'b01, 1'b1);
    run(3'd4, 4'd0, 64'hFFFF_FFFF_FFFF_FF3C, 64'h1111_1111_1111_113C, 2'b00, 1'b0);
    run(3'd4, 4'd0, 64'h0000_0000_0000_0042, 64'h4143_4443_4140_4443, 2'b00, 1'b0);
    // unrecognised codes
    for (int k = 5; k < 8; k++) run(3'(k), 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 2'b11, 1'b1);
    run(3'd0, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 2'b11, 1'b1);
    // 32-bit carry input has no effect
    run_ca32_pair(3'd1, 64'h0000_0000_FFFF_FFFF, 64'd0);
    run_ca32_pair(3'd3, 64'h0000_0000_FFFF_FFFF, 64'd0);
    run_ca32_pair(3'd2, 64'h0000_0000_8000_0000, 64'd0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] x, y;
      logic [3:0]  l;
      logic [2:0]  k;
      int sel;
      k = 3'($urandom_range(0, 7));
      sel = $urandom_range(0, 4);
      l = (sel == 0) ? 4'd1 : (sel == 1) ? 4'd2 : (sel == 2) ? 4'd4 : 4'($urandom);
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) y[8*$urandom_range(0, 7) +: 8] = x[7:0];
      if ($urandom_range(0, 3) == 0) y = {~x[63], y[62:0]};
      run(k, l, x, y, 2'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule